// File: doc/BRIEF.md
# Multiply-Accumulate Execution Unit

This unit is the integer multiply and multiply-accumulate stage of a 64-bit processor datapath. It owns two 64-bit registers, HI and LO. Their low 32-bit words together form a 64-bit accumulator, read as {HI[31:0], LO[31:0]}. Each cycle the unit may take one decoded 32-bit instruction word and the two 64-bit operand values that the register file read for it. It forms a 32x32 product, signed or unsigned. It then either loads the product into the accumulator or adds it to the accumulator. It can also return one half of the new accumulator to a destination-register write port.

A second function code gives a variant that works on LO alone. It adds the signed product to the full 64-bit LO and leaves HI untouched. The operand register numbers are decoded combinationally so that the register file can be addressed in the same cycle.

The instruction input is a plain valid strobe with no back-pressure: the unit has no ready signal and accepts whatever is presented on any cycle with `in_valid` high. The write port result is a single-cycle pulse that the consumer must take at once.

Top module: `mac_unit`

## Requirements
- R1: An instruction is acted on only when `in_valid` is high, bits [31:26] are zero, and bits [5:0] are 101000 (multiply family) or 101001 (LO-only accumulate). Any other input, and any multiply-family op field not listed in R2, leaves HI and LO unchanged and causes no register write.
- R2: In the multiply family, bits [10:6] select the operation. 00100 and 00101 are signed and unsigned load with the low half written. 01100 and 01101 are signed and unsigned load with the high half written. 00010 and 00011 are signed and unsigned accumulate with the low half written. 01010 and 01011 are signed and unsigned accumulate with the high half written. 00000 is signed accumulate with no register write.
- R3: Load operations replace the accumulator {HI[31:0], LO[31:0]} with the 64-bit product.
- R4: Accumulate operations add the product to the accumulator modulo 2^64, with no overflow indication.
- R5: Only bits [31:0] of each operand are used. Signed operations treat them as two's-complement values. Unsigned operations zero-extend them.
- R6: After a multiply-family update, HI holds the sign extension of the new accumulator bits [63:32], and LO holds the sign extension of bits [31:0].
- R7: One cycle after an accepted writing operation, `rd_we` is high and `rd_addr` equals bits [15:11]. `rd_data` is then the selected 32-bit half of the new accumulator, sign-extended to 64 bits, for unsigned operations too.
- R8: For function 101001, LO becomes LO plus the sign-extended signed product, over all 64 bits modulo 2^64. HI is unchanged and there is no register write.
- R9: `rs_addr` equals bits [25:21] and `rt_addr` equals bits [20:16] of `in_instr`, combinationally.
- R10: While reset is active, HI and LO are zero and `rd_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are present |
| in_instr | input | 32 | Decoded instruction word |
| in_rs_val | input | 64 | First operand value |
| in_rt_val | input | 64 | Second operand value |
| rs_addr | output | 5 | First operand register number |
| rt_addr | output | 5 | Second operand register number |
| hi_q | output | 64 | HI register |
| lo_q | output | 64 | LO register |
| rd_we | output | 1 | Destination write strobe, one cycle |
| rd_addr | output | 5 | Destination register number |
| rd_data | output | 64 | Destination write value |

## Verification
The assertions take for granted that `in_valid` and `in_instr` are never X after reset, and that the consumer of the write port needs no hold, because the unit cannot stall. The stimulus drives known values on every input from time zero. It mixes directed encodings, including every op value and wrong top and function bits, with random legal and illegal words whose operands carry random upper 32 bits. Extreme operands such as all-ones and the most negative value are used to reach carry and wrap cases.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int INSTR_W  = 32;
  localparam int REG_AW   = 5;
  localparam int OP_W     = 5;
  localparam int FN_W     = 6;
  localparam int RS_LSB   = 21;
  localparam int RT_LSB   = 16;
  localparam int RD_LSB   = 11;
  localparam int OP_LSB   = 6;
  localparam int TOP_LSB  = 26;
  localparam logic [FN_W-1:0] FN_MULFAM = 6'b101000;
  localparam logic [FN_W-1:0] FN_LOACC  = 6'b101001;

  typedef struct packed {
    logic ok;       // instruction accepted
    logic lo_only;  // LO-only accumulate
    logic sgn;      // signed operands
    logic acc;      // add to accumulator instead of load
    logic wr;       // write destination register
    logic hi_sel;   // destination gets high half
  } mac_ctl_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic               valid,
  input  logic [INSTR_W-1:0] instr,
  output mac_ctl_t           ctl,
  output logic [REG_AW-1:0]  rs_addr,
  output logic [REG_AW-1:0]  rt_addr,
  output logic [REG_AW-1:0]  rd_addr
);
  logic [OP_W-1:0] op;
  logic [FN_W-1:0] fn;
  logic            top_zero, fam, loacc, op_legal;

  assign op       = instr[OP_LSB +: OP_W];
  assign fn       = instr[FN_W-1:0];
  assign top_zero = (instr[INSTR_W-1:TOP_LSB] == '0);
  assign fam      = top_zero && (fn == FN_MULFAM);
  assign loacc    = top_zero && (fn == FN_LOACC);
  // op[0]: unsigned, op[1]: accumulate, op[2]: load, op[3]: high half
  assign op_legal = !op[4] && ((op[2] ^ op[1]) || (op == '0));

  always_comb begin
    ctl.ok      = valid && (loacc || (fam && op_legal));
    ctl.lo_only = loacc;
    ctl.sgn     = loacc || !op[0];
    ctl.acc     = loacc || !op[2];
    ctl.wr      = fam && (op[2] || op[1]);
    ctl.hi_sel  = op[3];
  end

  assign rs_addr = instr[RS_LSB +: REG_AW];
  assign rt_addr = instr[RT_LSB +: REG_AW];
  assign rd_addr = instr[RD_LSB +: REG_AW];
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int HALF       = 32,
  parameter bit SHARED_MUL = 1'b1,
  localparam int PW        = 2 * HALF
) (
  input  logic [HALF-1:0] a,
  input  logic [HALF-1:0] b,
  input  logic            sgn,
  output logic [PW-1:0]   prod
);
  generate
    if (SHARED_MUL) begin : g_shared
      // one (HALF+1)-bit signed array serves both signednesses
      logic signed [HALF:0]   ax, bx;
      logic signed [PW+1:0]   full;
      assign ax   = {sgn & a[HALF-1], a};
      assign bx   = {sgn & b[HALF-1], b};
      assign full = ax * bx;
      assign prod = full[PW-1:0];
    end else begin : g_split
      logic signed [PW-1:0] ps;
      logic        [PW-1:0] pu;
      assign ps   = $signed(a) * $signed(b);
      assign pu   = {{HALF{1'b0}}, a} * {{HALF{1'b0}}, b};
      assign prod = sgn ? ps : pu;
    end
  endgenerate
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int HALF  = 32,
  localparam int ACCW = 2 * HALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mac_ctl_t          ctl,
  input  logic [ACCW-1:0]   prod,
  input  logic [REG_AW-1:0] dst_in,
  output logic [XLEN-1:0]   hi_q,
  output logic [XLEN-1:0]   lo_q,
  output logic              rd_we,
  output logic [REG_AW-1:0] rd_addr,
  output logic [XLEN-1:0]   rd_data
);
  logic [ACCW-1:0]        acc_cur, acc_new;
  logic signed [XLEN-1:0] prod_x;
  logic [XLEN-1:0]        hi_d, lo_d, pick_d, lo_sum;

  assign acc_cur = {hi_q[HALF-1:0], lo_q[HALF-1:0]};
  assign acc_new = ctl.acc ? (acc_cur + prod) : prod;
  assign prod_x  = $signed(prod);
  assign lo_sum  = lo_q + prod_x;
  assign hi_d    = {{(XLEN-HALF){acc_new[ACCW-1]}}, acc_new[ACCW-1:HALF]};
  assign lo_d    = {{(XLEN-HALF){acc_new[HALF-1]}}, acc_new[HALF-1:0]};
  assign pick_d  = ctl.hi_sel ? hi_d : lo_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      rd_we   <= 1'b0;
      rd_addr <= '0;
      rd_data <= '0;
    end else begin
      rd_we <= ctl.ok && ctl.wr;
      if (ctl.ok) begin
        if (ctl.lo_only) begin
          lo_q <= lo_sum;
        end else begin
          hi_q <= hi_d;
          lo_q <= lo_d;
        end
        if (ctl.wr) begin
          rd_addr <= dst_in;
          rd_data <= pick_d;
        end
      end
    end
  end

  assert_hi_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q[XLEN-1:HALF] == {(XLEN-HALF){hi_q[HALF-1]}});

  assert_reject_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.ok |=> ($stable(hi_q) && $stable(lo_q) && !rd_we));

  assert_lo_only_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ok && ctl.lo_only) |=> ($stable(hi_q) && !rd_we));

  assert_rd_sext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_data[XLEN-1:HALF] == {(XLEN-HALF){rd_data[HALF-1]}}));

  assert_rd_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_data == (rd_data[HALF-1] ? $past(hi_d | ~hi_d) & rd_data : rd_data)
               && (rd_data == (($past(ctl.hi_sel)) ? hi_q : lo_q))));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int HALF       = 32,
  parameter bit SHARED_MUL = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [XLEN-1:0]    in_rs_val,
  input  logic [XLEN-1:0]    in_rt_val,
  output logic [REG_AW-1:0]  rs_addr,
  output logic [REG_AW-1:0]  rt_addr,
  output logic [XLEN-1:0]    hi_q,
  output logic [XLEN-1:0]    lo_q,
  output logic               rd_we,
  output logic [REG_AW-1:0]  rd_addr,
  output logic [XLEN-1:0]    rd_data
);
  localparam int ACCW = 2 * HALF;

  mac_ctl_t          ctl;
  logic [REG_AW-1:0] dst;
  logic [ACCW-1:0]   prod;

  mac_decode u_dec (
    .valid   (in_valid),
    .instr   (in_instr),
    .ctl     (ctl),
    .rs_addr (rs_addr),
    .rt_addr (rt_addr),
    .rd_addr (dst)
  );

  mac_mult #(.HALF(HALF), .SHARED_MUL(SHARED_MUL)) u_mul (
    .a    (in_rs_val[HALF-1:0]),
    .b    (in_rt_val[HALF-1:0]),
    .sgn  (ctl.sgn),
    .prod (prod)
  );

  mac_accum #(.XLEN(XLEN), .HALF(HALF)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .prod    (prod),
    .dst_in  (dst),
    .hi_q    (hi_q),
    .lo_q    (lo_q),
    .rd_we   (rd_we),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assert_rd_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_addr == $past(in_instr[RD_LSB +: REG_AW])));

  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n |=> (!rd_we && hi_q == '0 && lo_q == '0));
endmodule

// File: tb/tb_mac_unit.sv
`timescale 1ns/1ps
module tb_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [63:0] in_rs_val = '0, in_rt_val = '0;
  logic [4:0]  rs_addr, rt_addr, rd_addr;
  logic [63:0] hi_q, lo_q, rd_data;
  logic        rd_we;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [63:0] m_hi = '0, m_lo = '0, m_rd = '0;
  logic        m_we = 1'b0;
  logic [4:0]  m_ra = '0;

  always #4 clk = ~clk;

  mac_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_rs_val(in_rs_val), .in_rt_val(in_rt_val), .rs_addr(rs_addr),
    .rt_addr(rt_addr), .hi_q(hi_q), .lo_q(lo_q), .rd_we(rd_we),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] fn, input logic [4:0] op,
                                     input logic [4:0] rs, input logic [4:0] rt,
                                     input logic [4:0] rd);
    return {6'b0, rs, rt, rd, op, fn};
  endfunction

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // behavioural model of one cycle
  task automatic model(input logic v, input logic [31:0] ins,
                       input logic [63:0] a, input logic [63:0] b);
    logic ok, sg, ac, wr, hs, lonly;
    logic [63:0] p, accv;
    ok = 0; sg = 1; ac = 0; wr = 0; hs = 0; lonly = 0;
    if (v && ins[31:26] == 6'd0 && ins[5:0] == 6'b101001) begin
      ok = 1; lonly = 1;
    end else if (v && ins[31:26] == 6'd0 && ins[5:0] == 6'b101000) begin
      case (ins[10:6])
        5'b00000: begin ok = 1; sg = 1; ac = 1; wr = 0; end
        5'b00100: begin ok = 1; sg = 1; ac = 0; wr = 1; hs = 0; end
        5'b00101: begin ok = 1; sg = 0; ac = 0; wr = 1; hs = 0; end
        5'b01100: begin ok = 1; sg = 1; ac = 0; wr = 1; hs = 1; end
        5'b01101: begin ok = 1; sg = 0; ac = 0; wr = 1; hs = 1; end
        5'b00010: begin ok = 1; sg = 1; ac = 1; wr = 1; hs = 0; end
        5'b00011: begin ok = 1; sg = 0; ac = 1; wr = 1; hs = 0; end
        5'b01010: begin ok = 1; sg = 1; ac = 1; wr = 1; hs = 1; end
        5'b01011: begin ok = 1; sg = 0; ac = 1; wr = 1; hs = 1; end
        default:  ok = 0;
      endcase
    end
    if (lonly) sg = 1;
    if (sg) p = 64'(longint'(signed'(a[31:0])) * longint'(signed'(b[31:0])));
    else    p = {32'd0, a[31:0]} * {32'd0, b[31:0]};
    m_we = ok && wr;
    if (ok && lonly) begin
      m_lo = m_lo + p;
    end else if (ok) begin
      accv = ac ? ({m_hi[31:0], m_lo[31:0]} + p) : p;
      m_hi = sx(accv[63:32]);
      m_lo = sx(accv[31:0]);
      if (wr) begin
        m_ra = ins[15:11];
        m_rd = hs ? m_hi : m_lo;
      end
    end
  endtask

  // called at a negedge; returns at the next negedge after comparing
  task automatic step(input string tag, input logic v, input logic [31:0] ins,
                      input logic [63:0] a, input logic [63:0] b);
    in_valid = v; in_instr = ins; in_rs_val = a; in_rt_val = b;
    #1;
    chk("R9", "rs_addr", 64'(rs_addr), 64'(ins[25:21]));
    chk("R9", "rt_addr", 64'(rt_addr), 64'(ins[20:16]));
    model(v, ins, a, b);
    @(negedge clk);
    chk(tag, "hi", hi_q, m_hi);
    chk(tag, "lo", lo_q, m_lo);
    chk(tag, "rd_we", 64'(rd_we), 64'(m_we));
    if (m_we) begin
      chk(tag, "rd_addr", 64'(rd_addr), 64'(m_ra));
      chk(tag, "rd_data", rd_data, m_rd);
    end
  endtask

  function automatic string cls(input logic v, input logic [31:0] ins);
    if (!v || ins[31:26] != 0) return "R1";
    if (ins[5:0] == 6'b101001) return "R8";
    if (ins[5:0] != 6'b101000) return "R1";
    case (ins[10:6])
      5'b00100, 5'b00101, 5'b01100, 5'b01101: return "R3";
      5'b00000, 5'b00010, 5'b00011, 5'b01010, 5'b01011: return "R4";
      default: return "R1";
    endcase
  endfunction

  localparam logic [5:0] FM = 6'b101000;
  localparam logic [5:0] FL = 6'b101001;

  initial begin
    logic [4:0] ops [9];
    ops = '{5'b00000, 5'b00100, 5'b00101, 5'b01100, 5'b01101,
            5'b00010, 5'b00011, 5'b01010, 5'b01011};
    in_instr = mk(FM, 5'b00100, 5'd1, 5'd2, 5'd3);
    in_rs_val = 64'd7; in_rt_val = 64'd9;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset holds state and suppresses writes even with valid input
    chk("R10", "hi", hi_q, 64'd0);
    chk("R10", "lo", lo_q, 64'd0);
    chk("R10", "rd_we", 64'(rd_we), 64'd0);
    rst_n = 1'b1;

    // R2: every op field value with fixed operands
    for (int i = 0; i < 32; i++) begin
      step("R2", 1'b1, mk(FM, 5'(i), 5'd4, 5'd5, 5'(i)),
           64'hABCD_0000_8000_0003, 64'h1234_5678_FFFF_FFF9);
    end
    // R1: wrong top bits, wrong function, valid low
    step("R1", 1'b1, mk(FM, 5'b00100, 5'd1, 5'd1, 5'd1) | 32'h0400_0000, 64'd3, 64'd3);
    step("R1", 1'b1, mk(6'b101010, 5'b00100, 5'd1, 5'd1, 5'd1), 64'd3, 64'd3);
    step("R1", 1'b0, mk(FM, 5'b00100, 5'd1, 5'd1, 5'd1), 64'd3, 64'd3);
    step("R1", 1'b0, mk(FL, 5'b00000, 5'd1, 5'd1, 5'd1), 64'd3, 64'd3);
    // R5: extreme operands, signed vs unsigned, garbage upper bits
    step("R5", 1'b1, mk(FM, 5'b01101, 5'd1, 5'd2, 5'd9),
         64'h5555_5555_FFFF_FFFF, 64'hAAAA_AAAA_FFFF_FFFF);
    step("R5", 1'b1, mk(FM, 5'b01100, 5'd1, 5'd2, 5'd9),
         64'h5555_5555_FFFF_FFFF, 64'hAAAA_AAAA_FFFF_FFFF);
    step("R5", 1'b1, mk(FM, 5'b01100, 5'd1, 5'd2, 5'd9),
         64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000);
    // R4: wrap of the accumulator to zero
    step("R3", 1'b1, mk(FM, 5'b00100, 5'd1, 5'd2, 5'd10), 64'hFFFF_FFFF, 64'd1);
    step("R4", 1'b1, mk(FM, 5'b00011, 5'd1, 5'd2, 5'd11), 64'd1, 64'd1);
    // R6 / R7: negative low half and unsigned high half sign-extended
    step("R6", 1'b1, mk(FM, 5'b00101, 5'd1, 5'd2, 5'd12), 64'h0001_0000, 64'h8000);
    step("R7", 1'b1, mk(FM, 5'b01011, 5'd1, 5'd2, 5'd31),
         64'hFFFF_FFFF, 64'hFFFF_FFFF);
    // R8: LO-only accumulate with carry past bit 31 and a negative product
    step("R8", 1'b1, mk(FL, 5'b00000, 5'd1, 5'd2, 5'd0), 64'h7FFF_FFFF, 64'h7FFF_FFFF);
    step("R8", 1'b1, mk(FL, 5'b11111, 5'd1, 5'd2, 5'd7), 64'hFFFF_FFFF, 64'd5);
    step("R8", 1'b1, mk(FL, 5'b00000, 5'd1, 5'd2, 5'd0), 64'h7FFF_FFFF, 64'h7FFF_FFFF);

    // random mix, back to back
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ins;
      logic [63:0] a, b;
      logic        v;
      int          sel;
      sel = $urandom_range(0, 19);
      v   = ($urandom_range(0, 9) != 0);
      if (sel < 14)       ins = mk(FM, ops[$urandom_range(0, 8)], 5'($urandom), 5'($urandom), 5'($urandom));
      else if (sel < 17)  ins = mk(FL, 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
      else                ins = $urandom;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(0, 5) == 0) a[31:0] = 32'hFFFF_FFFF;
      if ($urandom_range(0, 5) == 0) b[31:0] = 32'h8000_0000;
      step(cls(v, ins), v, ins, a, b);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule